// File: doc/BRIEF.md
# Boot Configuration Loader

This block sets up a device's identity and recording settings from a small serial configuration memory as soon as reset is released. It reads the memory one byte at a time over a simple request/response port and captures the header bytes into staging registers. It then checks a two-byte signature. The settings it drives out are vendor ID, product ID, record gain, mute and input selection, gain limits, string presence flags, string lengths, selector disable, remote wakeup, boost and PLL adjustment. Each one is replaced by the stored value only when the signature is valid and, where one applies, the matching option flag is set. Until loading finishes, every setting holds its parameter default.

After loading, the same read port serves string fetches. A requester names one of three strings (manufacturer, product, serial) and a character index. The block finds the byte inside the packed string area and returns it widened to a 16-bit code unit. The bus master that performs the physical reads sits outside this block.

Top module: `cfg_boot_loader`

## Requirements
- R1: A read holds `mem_rd` high with a stable `mem_addr` until `mem_ack` or `mem_err` arrives. On the edge that accepts the response, `mem_rd` drops for at least one cycle.
- R2: Address 0x00 must hold 0x43 and address 0x01 must hold 0x4D. On a mismatch, loading stops after those two reads, `done`=1, `mem_ok`=0, and all settings keep their defaults.
- R3: A `mem_err` response to any header read takes the same path as R2. No further reads are issued.
- R4: `done` becomes 1 on the edge that accepts the final header response (address 0x12 when valid) and stays 1 until reset. Before that edge, every setting output equals its default.
- R5: With a valid signature, `vid` = {byte 0x0F, byte 0x0E} and `pid` = {byte 0x11, byte 0x10}. A valid load makes exactly 19 reads, covering addresses 0x00 to 0x12.
- R6: The flag byte at 0x02 drives the following outputs: `str_present[3:0]` from bits 3:0 (manufacturer, product, serial, general string), `sel_off` from bit 6, and `wake_en` from bit 7.
- R7: When flag bit 4 is set, byte 0x03 supplies `rec_gain` from bits 5:0, `rec_mute` from bit 6 and `rec_line` from bit 7 (1 = line input). When flag bit 4 is clear, these outputs keep their defaults.
- R8: When flag bit 5 is set, `gain_max` = {0x06, 0x05} and `gain_min` = {0x08, 0x07}. When flag bit 5 is clear, both keep their defaults.
- R9: `len_mfr`, `len_prod` and `len_ser` come from bytes 0x0B, 0x0C and 0x0D. Byte 0x12 drives `boost_en` from bit 0 and `pll_adj_en` from bit 1. Bit 2 of byte 0x12 is ignored.
- R10: After a valid load, a one-cycle `str_req` starts a fetch. The byte is read at 0x50 + `str_idx` plus `len_mfr` when `str_sel` is at least 1, plus `len_prod` when `str_sel` is 2 (8-bit wrap). Encodings are 0 = manufacturer, 1 = product, 2 = serial. The result appears as `str_unit` = {8'h00, byte}, with `str_valid` pulsing for one cycle on the edge that accepts the response.
- R11: After an invalid load, a request issues no memory read. `str_valid` pulses on the next edge with `str_unit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read request, held until answered |
| mem_addr | output | AW | Byte address of the request |
| mem_ack | input | 1 | One-cycle pulse: read data valid |
| mem_err | input | 1 | One-cycle pulse: memory did not acknowledge |
| mem_data | input | 8 | Read data, valid with `mem_ack` |
| done | output | 1 | Loading finished |
| mem_ok | output | 1 | Signature valid and overrides applied |
| vid | output | 16 | Vendor ID |
| pid | output | 16 | Product ID |
| str_present | output | 4 | String presence flags |
| sel_off | output | 1 | Selector disable |
| wake_en | output | 1 | Remote wakeup enable |
| rec_gain | output | 6 | Initial record gain code |
| rec_mute | output | 1 | Initial record mute |
| rec_line | output | 1 | 1 = line input, 0 = microphone |
| gain_max | output | 16 | Upper gain limit |
| gain_min | output | 16 | Lower gain limit |
| len_mfr | output | 8 | Manufacturer string length |
| len_prod | output | 8 | Product string length |
| len_ser | output | 8 | Serial string length |
| boost_en | output | 1 | 18 dB boost enable |
| pll_adj_en | output | 1 | PLL adjustment enable |
| str_req | input | 1 | String fetch request pulse |
| str_sel | input | 2 | String select |
| str_idx | input | 8 | Character index within the string |
| str_valid | output | 1 | Fetch result pulse |
| str_unit | output | 16 | Widened code unit |

## Verification
Settings are decoded combinationally from registers that are written on the same edge that raises `done`. The bench therefore waits for `done` at falling edges and compares every output in that same half-cycle. Before `done` rises, it samples three cycles after reset, when the defaults must still hold because a load needs at least two cycles per byte. A fetch result registers on the response edge. The bench polls `str_valid` at each falling edge after dropping `str_req`, so the one-cycle pulse cannot be missed. A read count taken by the memory model shows when loading stops early (R2, R3).

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter logic [15:0] DEF_VID  = 16'h1209,
  parameter logic [15:0] DEF_PID  = 16'h0001,
  parameter logic [5:0]  DEF_GAIN = 6'h10,
  parameter logic [15:0] DEF_MAX  = 16'h1E00,
  parameter logic [15:0] DEF_MIN  = 16'hF000,
  parameter int          AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [7:0]    mem_data,
  output logic          done,
  output logic          mem_ok,
  output logic [15:0]   vid,
  output logic [15:0]   pid,
  output logic [3:0]    str_present,
  output logic          sel_off,
  output logic          wake_en,
  output logic [5:0]    rec_gain,
  output logic          rec_mute,
  output logic          rec_line,
  output logic [15:0]   gain_max,
  output logic [15:0]   gain_min,
  output logic [7:0]    len_mfr,
  output logic [7:0]    len_prod,
  output logic [7:0]    len_ser,
  output logic          boost_en,
  output logic          pll_adj_en,
  input  logic          str_req,
  input  logic [1:0]    str_sel,
  input  logic [7:0]    str_idx,
  output logic          str_valid,
  output logic [15:0]   str_unit
);
  localparam logic [AW-1:0] LAST     = AW'(8'h12);
  localparam logic [AW-1:0] STR_BASE = AW'(8'h50);

  logic        loading, fetching, ok_q;
  logic [7:0]  sig0, flags, rec, lm, lp, ls;
  logic [1:0]  misc;
  logic [15:0] vid_q, pid_q, max_q, min_q;
  logic [AW-1:0] str_addr;

  wire resp   = mem_ack | mem_err;
  wire apply  = done & ok_q;
  wire rec_on = apply & flags[4];
  wire lim_on = apply & flags[5];
  wire sig_bad = (mem_addr == AW'(8'h01)) && ({mem_data, sig0} != 16'h4D43);

  assign str_addr = STR_BASE + AW'(str_idx)
                  + ((str_sel != 2'd0) ? AW'(lm) : '0)
                  + (str_sel[1] ? AW'(lp) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b1; fetching <= 1'b0; ok_q <= 1'b0; done <= 1'b0;
      mem_rd <= 1'b0; mem_addr <= '1;
      sig0 <= '0; flags <= '0; rec <= '0; lm <= '0; lp <= '0; ls <= '0; misc <= '0;
      vid_q <= '0; pid_q <= '0; max_q <= '0; min_q <= '0;
      str_valid <= 1'b0; str_unit <= '0;
    end else begin
      str_valid <= 1'b0;
      if (loading) begin
        if (mem_rd && resp) begin
          mem_rd <= 1'b0;
          if (mem_err || sig_bad) begin
            loading <= 1'b0; done <= 1'b1;
          end else begin
            case (mem_addr[7:0])
              8'h00: sig0 <= mem_data;
              8'h02: flags <= mem_data;
              8'h03: rec <= mem_data;
              8'h05: max_q[7:0] <= mem_data;
              8'h06: max_q[15:8] <= mem_data;
              8'h07: min_q[7:0] <= mem_data;
              8'h08: min_q[15:8] <= mem_data;
              8'h0B: lm <= mem_data;
              8'h0C: lp <= mem_data;
              8'h0D: ls <= mem_data;
              8'h0E: vid_q[7:0] <= mem_data;
              8'h0F: vid_q[15:8] <= mem_data;
              8'h10: pid_q[7:0] <= mem_data;
              8'h11: pid_q[15:8] <= mem_data;
              8'h12: misc <= mem_data[1:0];
              default: ;
            endcase
            if (mem_addr == LAST) begin
              loading <= 1'b0; done <= 1'b1; ok_q <= 1'b1;
            end
          end
        end else if (!mem_rd) begin
          mem_rd <= 1'b1;
          mem_addr <= mem_addr + 1'b1;
        end
      end else if (fetching) begin
        if (resp) begin
          mem_rd <= 1'b0; fetching <= 1'b0; str_valid <= 1'b1;
          str_unit <= mem_err ? 16'h0000 : {8'h00, mem_data};
        end
      end else if (done && str_req) begin
        if (ok_q) begin
          fetching <= 1'b1; mem_rd <= 1'b1; mem_addr <= str_addr;
        end else begin
          str_valid <= 1'b1; str_unit <= 16'h0000;
        end
      end
    end
  end

  assign mem_ok      = apply;
  assign vid         = apply ? vid_q : DEF_VID;
  assign pid         = apply ? pid_q : DEF_PID;
  assign str_present = apply ? flags[3:0] : 4'h0;
  assign sel_off     = apply & flags[6];
  assign wake_en     = apply & flags[7];
  assign rec_gain    = rec_on ? rec[5:0] : DEF_GAIN;
  assign rec_mute    = rec_on & rec[6];
  assign rec_line    = rec_on & rec[7];
  assign gain_max    = lim_on ? max_q : DEF_MAX;
  assign gain_min    = lim_on ? min_q : DEF_MIN;
  assign len_mfr     = apply ? lm : 8'h00;
  assign len_prod    = apply ? lp : 8'h00;
  assign len_ser     = apply ? ls : 8'h00;
  assign boost_en    = apply & misc[0];
  assign pll_adj_en  = apply & misc[1];

  a_r1_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !resp) |=> (mem_rd && $stable(mem_addr)));
  a_r1_gap_after_response: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && resp) |=> !mem_rd);
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r11_no_read_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_ok) |=> !mem_rd);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    str_valid |=> !str_valid);
endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb;
  localparam logic [15:0] DV = 16'h1209, DP = 16'h0001, DMX = 16'h1E00, DMN = 16'hF000;
  localparam logic [5:0]  DG = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        mem_rd, mem_ack = 1'b0, mem_err = 1'b0;
  logic [7:0]  mem_addr, mem_data = 8'h00;
  logic        done, mem_ok, sel_off, wake_en, rec_mute, rec_line, boost_en, pll_adj_en, str_valid;
  logic [15:0] vid, pid, gain_max, gain_min, str_unit;
  logic [3:0]  str_present;
  logic [5:0]  rec_gain;
  logic [7:0]  len_mfr, len_prod, len_ser;
  logic        str_req = 1'b0;
  logic [1:0]  str_sel = 2'd0;
  logic [7:0]  str_idx = 8'h00;

  logic [7:0] img [256];
  int  checks = 0, errors = 0, nreads = 0;
  logic nack_en = 1'b0;
  logic [7:0] nack_at = 8'h00;

  cfg_boot_loader #(.DEF_VID(DV), .DEF_PID(DP), .DEF_GAIN(DG), .DEF_MAX(DMX),
                    .DEF_MIN(DMN), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_data(mem_data), .done(done), .mem_ok(mem_ok), .vid(vid),
    .pid(pid), .str_present(str_present), .sel_off(sel_off), .wake_en(wake_en),
    .rec_gain(rec_gain), .rec_mute(rec_mute), .rec_line(rec_line), .gain_max(gain_max),
    .gain_min(gain_min), .len_mfr(len_mfr), .len_prod(len_prod), .len_ser(len_ser),
    .boost_en(boost_en), .pll_adj_en(pll_adj_en), .str_req(str_req), .str_sel(str_sel),
    .str_idx(str_idx), .str_valid(str_valid), .str_unit(str_unit));

  initial begin : responder
    int wcnt; bit served;
    wcnt = 0; served = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      if (!rst_n) begin served = 0; wcnt = 0; end
      else if (mem_rd && !served) begin
        if (wcnt == 0) begin
          if (nack_en && mem_addr == nack_at) mem_err = 1'b1;
          else begin mem_ack = 1'b1; mem_data = img[mem_addr]; end
          served = 1; nreads++; wcnt = $urandom_range(0, 2);
        end else wcnt--;
      end else if (!mem_rd) served = 0;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mk_img(input logic [7:0] fl);
    for (int a = 0; a < 256; a++) img[a] = 8'($urandom);
    img[0] = 8'h43; img[1] = 8'h4D; img[2] = fl;
    img[11] = 8'($urandom_range(0, 20));
    img[12] = 8'($urandom_range(0, 20));
    img[13] = 8'($urandom_range(0, 20));
  endtask

  task automatic load_and_wait();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    nreads = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4", "done early", 32'(done), 32'd0);
    chk("R4", "vid before done", 32'(vid), 32'(DV));
    chk("R4", "gain_max before done", 32'(gain_max), 32'(DMX));
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  task automatic check_good();
    logic [7:0] fl;
    fl = img[2];
    chk("R5", "reads", 32'(nreads), 32'd19);
    chk("R4", "done", 32'(done), 32'd1);
    chk("R2", "mem_ok", 32'(mem_ok), 32'd1);
    chk("R5", "vid", 32'(vid), {16'h0, img[15], img[14]});
    chk("R5", "pid", 32'(pid), {16'h0, img[17], img[16]});
    chk("R6", "str_present", 32'(str_present), 32'(fl[3:0]));
    chk("R6", "sel_off", 32'(sel_off), 32'(fl[6]));
    chk("R6", "wake_en", 32'(wake_en), 32'(fl[7]));
    chk("R7", "rec_gain", 32'(rec_gain), fl[4] ? 32'(img[3][5:0]) : 32'(DG));
    chk("R7", "rec_mute", 32'(rec_mute), fl[4] ? 32'(img[3][6]) : 32'd0);
    chk("R7", "rec_line", 32'(rec_line), fl[4] ? 32'(img[3][7]) : 32'd0);
    chk("R8", "gain_max", 32'(gain_max), fl[5] ? {16'h0, img[6], img[5]} : 32'(DMX));
    chk("R8", "gain_min", 32'(gain_min), fl[5] ? {16'h0, img[8], img[7]} : 32'(DMN));
    chk("R9", "len_mfr", 32'(len_mfr), 32'(img[11]));
    chk("R9", "len_prod", 32'(len_prod), 32'(img[12]));
    chk("R9", "len_ser", 32'(len_ser), 32'(img[13]));
    chk("R9", "boost_en", 32'(boost_en), 32'(img[18][0]));
    chk("R9", "pll_adj_en", 32'(pll_adj_en), 32'(img[18][1]));
  endtask

  task automatic check_bad(input string req, input int exp_reads);
    chk(req, "reads", 32'(nreads), 32'(exp_reads));
    chk(req, "done", 32'(done), 32'd1);
    chk(req, "mem_ok", 32'(mem_ok), 32'd0);
    chk(req, "vid", 32'(vid), 32'(DV));
    chk(req, "pid", 32'(pid), 32'(DP));
    chk(req, "rec_gain", 32'(rec_gain), 32'(DG));
    chk(req, "gain_min", 32'(gain_min), 32'(DMN));
    chk(req, "flags", {sel_off, wake_en, str_present}, 32'd0);
    chk(req, "len_mfr", 32'(len_mfr), 32'd0);
  endtask

  task automatic fetch(input string req, input logic [1:0] sel, input logic [7:0] idx, input logic [15:0] exp);
    bit got;
    got = 0;
    @(negedge clk);
    str_req = 1'b1; str_sel = sel; str_idx = idx;
    @(negedge clk);
    str_req = 1'b0;
    for (int i = 0; i < 50 && !got; i++) begin
      if (str_valid) begin
        got = 1;
        chk(req, "str_unit", 32'(str_unit), 32'(exp));
      end else @(negedge clk);
    end
    if (!got) chk(req, "str_valid", 32'd0, 32'd1);
  endtask

  function automatic logic [15:0] exp_unit(input logic [1:0] sel, input logic [7:0] idx);
    logic [7:0] a;
    a = 8'h50 + idx + ((sel != 2'd0) ? img[11] : 8'h00) + ((sel == 2'd2) ? img[12] : 8'h00);
    return {8'h00, img[a]};
  endfunction

  initial begin
    int seed;
    logic [7:0] fl;
    seed = $urandom(32'h5eed);
    for (int n = 0; n < 8; n++) begin
      if (n == 0) fl = 8'h00;
      else if (n == 1) fl = 8'hFF;
      else fl = 8'($urandom);
      mk_img(fl);
      if (n == 2) img[18] = 8'h04;
      load_and_wait();
      check_good();
      for (int k = 0; k < 3; k++) begin
        logic [1:0] s;
        logic [7:0] ix;
        s = 2'(k);
        ix = 8'($urandom_range(0, 25));
        fetch("R10", s, ix, exp_unit(s, ix));
      end
    end
    mk_img(8'hFF); img[0] = 8'h42;
    load_and_wait();
    check_bad("R2", 2);
    fetch("R11", 2'd1, 8'h03, 16'h0000);
    chk("R11", "no read", 32'(nreads), 32'd2);
    mk_img(8'hFF); img[1] = 8'h4C;
    load_and_wait();
    check_bad("R2", 2);
    mk_img(8'hFF); nack_en = 1'b1; nack_at = 8'h07;
    load_and_wait();
    check_bad("R3", 8);
    nack_en = 1'b0;
    summary();
    $finish;
  end
endmodule